// File: doc/BRIEF.md
# Text Decoder Control Register Bank with I2C Slave

This block is the host side of a text-display decoder. It is a byte-wide I2C slave that holds eleven write-only control registers and presents them to the rest of the chip on one parallel bus. Through a single data register it also gives the host access to an on-chip page memory.

Three of the control registers form the memory pointer: the chapter register selects one of four pages, the row register holds 0 to 24, and the column register holds 0 to 39. Every byte that passes through the data register moves the pointer forward by one column. At the end of a row it wraps to column 0 of the next row, and the last row wraps to row 0. A host can therefore stream a whole row with one transfer.

The data register shares its index with a read-only status byte. Bit 0 of register 0 decides which of the two a read returns. A write to that index always goes to the memory. The page memory itself is outside the block and is reached through a simple address, write strobe and read data port.

Top module: `ttx_ctrl_regbank`

## Requirements
- R1: The slave ACKs only the 7-bit address 0010001 (written on the bus as 0x22 for a write and 0x23 for a read). Any other address gets no ACK, and the bytes that follow it change no register.
- R2: In a write transfer, the first byte after the address is the register index and later bytes are data. Indices 0 to 10 address control registers, and the index advances by one after each data byte. Index 11 is the data register and keeps the index at 11. An index byte above 11 parks the transfer: later writes are ignored and reads return 0xFF.
- R3: After reset every register is 0x00 except registers 5 and 6, which are 0x03. Register n appears on `regs_o[8n+7:8n]`.
- R4: Reads at indices 0 to 10 return 0xFF, because the slave leaves SDA released.
- R5: A read at index 11 when bit 0 of register 0 is 1 returns the status byte {rate60 AND sync_good, 000000, sync_good} and does not move the pointer. When that bit is 0, the read returns the memory byte at the pointer.
- R6: A write at index 11 always goes to memory, whatever bit 0 of register 0 holds. It raises `mem_we_o` for one cycle, with address chapter*1000 + row*40 + column, where chapter is register 8 bits 1:0, row is register 9 and column is register 10.
- R7: Each memory access through index 11 adds one to register 10. When register 10 is 39, it becomes 0 and register 9 advances by one, and a row of 24 becomes 0.
- R8: A read transfer starts at the index left by the previous transfer. The index also advances after each byte read at indices 0 to 10.
- R9: The slave ACKs every data byte written to it. After the master NACKs a read byte, the slave keeps SDA released.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | Open-drain drive: 1 pulls SDA low |
| sync_good_i | input | 1 | Sync quality is good |
| rate60_i | input | 1 | Incoming field rate is 60 Hz |
| regs_o | output | 88 | Registers 0 to 10, packed with register n at bits 8n+7:8n |
| mem_addr_o | output | 12 | Page memory address built from the pointer |
| mem_we_o | output | 1 | One-cycle page memory write strobe |
| mem_wdata_o | output | 8 | Page memory write data |
| mem_rdata_i | input | 8 | Page memory read data, combinational from the address |

## Verification
The assertions assume that SCL holds each level for several system clocks. They also assume that SDA moves while SCL is high only to form a start or stop condition, and never while the slave itself is pulling the line low. The bench drives every bus phase for at least four clocks and changes SDA only inside SCL-low phases. Pointer values written by the bench stay within 24 rows and 40 columns, so every memory address stays inside the 4000-byte space the bench models.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
    localparam int NREG      = 11;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 4;
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(NREG);
    localparam logic [IDX_W-1:0] IDX_PARK = IDX_W'(NREG + 1);
    localparam int R_SEL  = 0;
    localparam int R_CHAP = 8;
    localparam int R_ROW  = 9;
    localparam int R_COL  = 10;
    localparam logic [7:0] LAST_COL  = 8'd39;
    localparam logic [7:0] LAST_ROW  = 8'd24;
    localparam int ROW_SPAN  = int'(LAST_COL) + 1;
    localparam int CHAP_SPAN = ROW_SPAN * (int'(LAST_ROW) + 1);
    localparam logic [7:0] FLOAT_BYTE = 8'hFF;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_AACK, L_WDAT, L_WACK, L_RDAT, L_RACK
    } link_st_e;

    function automatic byte_t reg_reset(int i);
        return (i == 5 || i == 6) ? 8'h03 : 8'h00;
    endfunction
endpackage

// File: rtl/ttx_i2c_link.sv
module ttx_i2c_link
    import ttx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0010001
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl_i,
    input  logic  sda_i,
    output logic  sda_oe_o,
    output logic  wr_stb_o,
    output logic  wr_first_o,
    output byte_t wr_byte_o,
    output logic  rd_req_o,
    input  byte_t rd_byte_i
);
    typedef struct packed {
        link_st_e   st;
        logic [1:0] scl_sy;
        logic [1:0] sda_sy;
        logic       scl_old;
        logic       sda_old;
        byte_t      sh;
        logic [3:0] cnt;
        logic       rnw;
        logic       first;
        logic       oe;
        logic       mack;
    } link_s;

    link_s q, n;
    logic scl, sda, rise, fall, start_c, stop_c;

    assign scl     = q.scl_sy[1];
    assign sda     = q.sda_sy[1];
    assign rise    = scl & ~q.scl_old;
    assign fall    = ~scl & q.scl_old;
    assign start_c = scl & q.scl_old & q.sda_old & ~sda;
    assign stop_c  = scl & q.scl_old & ~q.sda_old & sda;

    always_comb begin
        n          = q;
        wr_stb_o   = 1'b0;
        rd_req_o   = 1'b0;
        n.scl_sy   = {q.scl_sy[0], scl_i};
        n.sda_sy   = {q.sda_sy[0], sda_i};
        n.scl_old  = scl;
        n.sda_old  = sda;
        if (start_c) begin
            n.st  = L_ADDR;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else if (stop_c) begin
            n.st = L_IDLE;
            n.oe = 1'b0;
        end else begin
            case (q.st)
                L_ADDR, L_WDAT: begin
                    if (rise) begin
                        n.sh  = {q.sh[6:0], sda};
                        n.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        if (q.st == L_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                n.oe    = 1'b1;
                                n.rnw   = q.sh[0];
                                n.first = 1'b1;
                                n.st    = L_AACK;
                            end else begin
                                n.st = L_IDLE;
                            end
                        end else begin
                            wr_stb_o = 1'b1;
                            n.oe     = 1'b1;
                            n.st     = L_WACK;
                        end
                    end
                end
                L_AACK, L_RACK: begin
                    if (rise && q.st == L_RACK) begin
                        n.mack = ~sda;
                    end else if (fall) begin
                        if (q.st == L_AACK && !q.rnw) begin
                            n.oe  = 1'b0;
                            n.cnt = '0;
                            n.st  = L_WDAT;
                        end else if (q.st == L_AACK || q.mack) begin
                            rd_req_o = 1'b1;
                            n.sh     = rd_byte_i;
                            n.oe     = ~rd_byte_i[7];
                            n.cnt    = 4'd1;
                            n.st     = L_RDAT;
                        end else begin
                            n.oe = 1'b0;
                            n.st = L_IDLE;
                        end
                    end
                end
                L_WACK: begin
                    if (fall) begin
                        n.oe    = 1'b0;
                        n.cnt   = '0;
                        n.first = 1'b0;
                        n.st    = L_WDAT;
                    end
                end
                L_RDAT: begin
                    if (fall) begin
                        if (q.cnt == 4'd8) begin
                            n.oe = 1'b0;
                            n.st = L_RACK;
                        end else begin
                            n.oe  = ~q.sh[6];
                            n.sh  = {q.sh[6:0], 1'b1};
                            n.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= L_IDLE;
            q.scl_sy <= 2'b11;
            q.sda_sy <= 2'b11;
            q.scl_old <= 1'b1;
            q.sda_old <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o   = q.oe;
    assign wr_first_o = q.first;
    assign wr_byte_o  = q.sh;
endmodule

// File: rtl/ttx_regfile.sv
module ttx_regfile
    import ttx_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb_i,
    input  logic                  wr_first_i,
    input  byte_t                 wr_byte_i,
    input  logic                  rd_req_i,
    output byte_t                 rd_byte_o,
    input  logic                  sync_good_i,
    input  logic                  rate60_i,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic [MEM_AW-1:0]     mem_addr_o,
    output logic                  mem_we_o,
    output byte_t                 mem_wdata_o,
    input  byte_t                 mem_rdata_i
);
    typedef struct packed {
        byte_t [NREG-1:0] regs;
        logic [IDX_W-1:0] idx;
    } rf_s;

    function automatic rf_s rst_state();
        rf_s s;
        for (int i = 0; i < NREG; i++) s.regs[i] = reg_reset(i);
        s.idx = '0;
        return s;
    endfunction

    rf_s   q, n;
    logic  advance;
    byte_t status;

    assign status = {rate60_i & sync_good_i, 6'b0, sync_good_i};

    always_comb begin
        n         = q;
        mem_we_o  = 1'b0;
        advance   = 1'b0;
        rd_byte_o = FLOAT_BYTE;
        if (q.idx == IDX_DATA)
            rd_byte_o = q.regs[R_SEL][0] ? status : mem_rdata_i;
        if (wr_stb_i) begin
            if (wr_first_i) begin
                n.idx = (wr_byte_i > byte_t'(IDX_DATA)) ? IDX_PARK : wr_byte_i[IDX_W-1:0];
            end else if (q.idx < IDX_DATA) begin
                n.regs[q.idx] = wr_byte_i;
                n.idx         = q.idx + 1'b1;
            end else if (q.idx == IDX_DATA) begin
                mem_we_o = 1'b1;
                advance  = 1'b1;
            end
        end else if (rd_req_i) begin
            if (q.idx < IDX_DATA)
                n.idx = q.idx + 1'b1;
            else if (q.idx == IDX_DATA && !q.regs[R_SEL][0])
                advance = 1'b1;
        end
        if (advance) begin
            if (q.regs[R_COL] >= LAST_COL) begin
                n.regs[R_COL] = 8'd0;
                n.regs[R_ROW] = (q.regs[R_ROW] >= LAST_ROW) ? 8'd0 : q.regs[R_ROW] + 8'd1;
            end else begin
                n.regs[R_COL] = q.regs[R_COL] + 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rst_state();
        else        q <= n;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[g*BYTE_W +: BYTE_W] = q.regs[g];
    end

    assign mem_addr_o  = MEM_AW'(int'(q.regs[R_CHAP][1:0]) * CHAP_SPAN
                               + int'(q.regs[R_ROW]) * ROW_SPAN
                               + int'(q.regs[R_COL]));
    assign mem_wdata_o = wr_byte_i;
endmodule

// File: rtl/ttx_ctrl_regbank.sv
module ttx_ctrl_regbank
    import ttx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0010001,
    parameter int         MEM_AW   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic                   sync_good_i,
    input  logic                   rate60_i,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic [MEM_AW-1:0]      mem_addr_o,
    output logic                   mem_we_o,
    output logic [BYTE_W-1:0]      mem_wdata_o,
    input  logic [BYTE_W-1:0]      mem_rdata_i
);
    logic  wr_stb, wr_first, rd_req;
    byte_t wr_byte, rd_byte;

    ttx_i2c_link #(.DEV_ADDR(DEV_ADDR)) i_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_oe_o   (sda_oe_o),
        .wr_stb_o   (wr_stb),
        .wr_first_o (wr_first),
        .wr_byte_o  (wr_byte),
        .rd_req_o   (rd_req),
        .rd_byte_i  (rd_byte)
    );

    ttx_regfile #(.MEM_AW(MEM_AW)) i_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb_i    (wr_stb),
        .wr_first_i  (wr_first),
        .wr_byte_i   (wr_byte),
        .rd_req_i    (rd_req),
        .rd_byte_o   (rd_byte),
        .sync_good_i (sync_good_i),
        .rate60_i    (rate60_i),
        .regs_o      (regs_o),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i)
    );
endmodule

// File: rtl/ttx_regbank_chk.sv
module ttx_regbank_chk
    import ttx_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe_o,
    input logic                   mem_we_o,
    input logic [NREG*BYTE_W-1:0] regs_o
);
    byte_t col, row;
    assign col = regs_o[R_COL*BYTE_W +: BYTE_W];
    assign row = regs_o[R_ROW*BYTE_W +: BYTE_W];

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (regs_o[5*BYTE_W +: BYTE_W] == 8'h03 && regs_o[6*BYTE_W +: BYTE_W] == 8'h03
                           && regs_o[R_SEL*BYTE_W +: BYTE_W] == 8'h00)); // R3

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe_o)); // R10

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && col < LAST_COL) |=> (col == 8'($past(col) + 8'd1) && $stable(row))); // R7

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && col >= LAST_COL) |=>
            (col == 8'd0 && row == (($past(row) >= LAST_ROW) ? 8'd0 : 8'($past(row) + 8'd1)))); // R7

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o); // R6
endmodule

bind ttx_ctrl_regbank ttx_regbank_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .mem_we_o (mem_we_o),
    .regs_o   (regs_o)
);

// File: tb/test_ttx_ctrl_regbank.sv
module test_ttx_ctrl_regbank;
    import ttx_pkg::*;

    localparam logic [6:0] DEV = 7'b0010001;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sync_good = 1'b0, rate60 = 1'b0;
    logic sda_oe, sda_line, mem_we;
    logic [NREG*8-1:0] regs;
    logic [11:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [7:0] ram [0:4095];
    logic [7:0] m_ram [0:4095];
    logic [7:0] m_reg [0:NREG-1];
    int m_idx = 0;
    int n_cmp = 0, n_bad = 0;
    bit settled = 1'b0;
    logic [NREG*8-1:0] exp_v;

    always #5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    ttx_ctrl_regbank i_ttx_ctrl_regbank (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .sync_good_i(sync_good), .rate60_i(rate60), .regs_o(regs),
        .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata)
    );

    // reference register state compared on every clock once settled (R2, R3, R7)
    always @(negedge clk) begin
        if (rst_n && settled) begin
            for (int k = 0; k < NREG; k++) exp_v[k*8 +: 8] = m_reg[k];
            n_cmp++;
            if (regs !== exp_v) begin
                n_bad++;
                $display("FAIL R3 register state: actual %h expected %h", regs, exp_v);
            end
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired: actual hung expected done");
        report();
        $finish;
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int maddr();
        return int'(m_reg[R_CHAP][1:0]) * 1000 + int'(m_reg[R_ROW]) * 40 + int'(m_reg[R_COL]);
    endfunction

    function automatic void madv();
        if (m_reg[R_COL] >= 39) begin
            m_reg[R_COL] = 0;
            m_reg[R_ROW] = (m_reg[R_ROW] >= 24) ? 8'd0 : m_reg[R_ROW] + 8'd1;
        end else m_reg[R_COL] = m_reg[R_COL] + 8'd1;
    endfunction

    function automatic void mdl_wr(bit first, logic [7:0] b);
        if (first) m_idx = (b > 11) ? 12 : int'(b);
        else if (m_idx < 11) begin m_reg[m_idx] = b; m_idx++; end
        else if (m_idx == 11) begin m_ram[maddr()] = b; madv(); end
    endfunction

    function automatic logic [7:0] mdl_rd();
        logic [7:0] r = 8'hFF;
        if (m_idx < 11) m_idx++;
        else if (m_idx == 11) begin
            if (m_reg[R_SEL][0]) r = {rate60 & sync_good, 6'b0, sync_good};
            else begin r = m_ram[maddr()]; madv(); end
        end
        return r;
    endfunction

    task automatic wt(int n); repeat (n) @(posedge clk); #2; endtask

    task automatic i2c_start();
        scl = 1'b0; wt(4); sda_m = 1'b1; wt(4); scl = 1'b1; wt(8); sda_m = 1'b0; wt(8);
    endtask

    task automatic i2c_stop();
        scl = 1'b0; wt(4); sda_m = 1'b0; wt(4); scl = 1'b1; wt(8); sda_m = 1'b1; wt(8);
    endtask

    task automatic send_byte(logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; wt(4); sda_m = b[i]; wt(4); scl = 1'b1; wt(8);
        end
        settled = 1'b0;
        scl = 1'b0; wt(4); sda_m = 1'b1; wt(4); scl = 1'b1; wt(4); ack = !sda_line; wt(4);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit nack);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; wt(2); sda_m = 1'b1; wt(6); scl = 1'b1; wt(4); b[i] = sda_line; wt(4);
        end
        scl = 1'b0; wt(4); sda_m = nack; wt(4); scl = 1'b1; wt(8);
    endtask

    task automatic wr_tx(logic [6:0] a, logic [7:0] d[$]);
        bit ack;
        i2c_start();
        send_byte({a, 1'b0}, ack);
        chk((a == DEV) ? "R1 address ACK" : "R1 foreign address NACK", int'(ack), int'(a == DEV));
        if (ack) begin
            foreach (d[i]) begin
                send_byte(d[i], ack);
                chk("R9 data byte ACK", int'(ack), 1);
                mdl_wr(i == 0, d[i]);
                settled = 1'b1;
            end
        end
        settled = 1'b1;
        i2c_stop();
    endtask

    task automatic rd_tx(int n, string tag);
        bit ack;
        logic [7:0] b;
        settled = 1'b0;
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        chk("R1 read address ACK", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i == n - 1);
            chk(tag, int'(b), int'(mdl_rd()));
        end
        scl = 1'b0; wt(8);
        chk("R9 SDA released after NACK", int'(sda_oe), 0);
        wt(8);
        chk("R9 SDA still released", int'(sda_oe), 0);
        i2c_stop();
        settled = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin ram[i] = 8'h20; m_ram[i] = 8'h20; end
        for (int k = 0; k < NREG; k++) m_reg[k] = reg_reset(k);
        wt(5);
        rst_n = 1'b1;
        wt(2);
        settled = 1'b1;
        chk("R3 reset value of register 5", int'(regs[5*8 +: 8]), 8'h03);
        chk("R3 reset value of register 6", int'(regs[6*8 +: 8]), 8'h03);
        chk("R3 reset value of register 0", int'(regs[7:0]), 0);

        wr_tx(DEV, {8'h00, 8'h00, 8'h12, 8'h34, 8'h56});
        chk("R2 consecutive write register 3", int'(regs[3*8 +: 8]), 8'h56);

        wr_tx(DEV, {8'h08, 8'h01, 8'h03, 8'h26, 8'hD0, 8'hD1, 8'hD2});
        chk("R7 row after column wrap", int'(regs[R_ROW*8 +: 8]), 4);
        chk("R7 column after wrap", int'(regs[R_COL*8 +: 8]), 1);
        chk("R6 memory byte at chapter 1 row 3 col 39", int'(ram[1159]), 8'hD1);

        wr_tx(DEV, {8'h00, 8'h01});
        wr_tx(DEV, {8'h0B, 8'h55});
        chk("R6 write lands in memory with status selected", int'(ram[1161]), 8'h55);

        sync_good = 1'b1; rate60 = 1'b1;
        rd_tx(1, "R5 status read good 60Hz");
        sync_good = 1'b0;
        rd_tx(1, "R5 status read sync bad");
        chk("R5 pointer untouched by status read", int'(regs[R_COL*8 +: 8]), 2);

        wr_tx(DEV, {8'h00, 8'h00});
        wr_tx(DEV, {8'h09, 8'h03, 8'h26});
        rd_tx(4, "R5 R7 memory stream read");

        wr_tx(DEV, {8'h02});
        rd_tx(3, "R4 write-only register reads");
        rd_tx(7, "R8 read continues from last index");

        wr_tx(DEV, {8'h09, 8'd24, 8'd39, 8'h77});
        chk("R7 row wraps from 24 to 0", int'(regs[R_ROW*8 +: 8]), 0);
        wr_tx(DEV, {8'h09, 8'd24, 8'd39});
        rd_tx(2, "R7 read across last row");

        wr_tx(DEV, {8'h30, 8'hAA, 8'hBB});
        chk("R2 parked index ignores writes", int'(regs[1*8 +: 8]), 8'h12);
        rd_tx(1, "R2 parked index reads float");

        wr_tx(7'h22, {8'h01, 8'hEE});
        chk("R1 foreign address leaves register 1", int'(regs[1*8 +: 8]), 8'h12);

        wt(20);
        report();
        $finish;
    end
endmodule